// File: doc/BRIEF.md
# Inter-Processor and Interval-Timer Interrupt Hub

This block keeps, for each of up to four CPUs, one pending bit for an inter-processor interrupt (IPI) and one pending bit for the interval timer. Each pending bit drives that CPU's interrupt line directly. A periodic tick from outside sets the timer bit of every CPU. Software posts and acknowledges interrupts through a 64-bit register bus. One control register packs several independent commands into separate nibble fields of a single write. Three dedicated registers post IPIs, acknowledge IPIs and acknowledge timer interrupts one at a time.

Each request takes one cycle. Its response (`rsp_valid`, read data, error) and two warning pulses are registered and appear in the following cycle. The warnings report a post to a CPU whose IPI is already pending and an acknowledge of an IPI that is not pending. A write that carries no command, a dedicated write with an empty CPU mask, and any access to an unmapped register index are answered with an error and change no state.

Top module: `cpu_irq_hub`

## Requirements
- R1: After reset all IPI and timer pending bits are 0, so `ipi_irq` and `tmr_irq` are 0, and `warn_dup`, `warn_spur` and `rsp_valid` are 0.
- R2: A write to the control register (index 0) posts an IPI to CPU i when bit 12+i is set. `ipi_irq[i]` is the IPI pending bit of CPU i.
- R3: In a control write, bit 8+i acknowledges the IPI of CPU i. When one write both acknowledges and posts for the same CPU, the acknowledge takes effect first, so that CPU ends up pending and no warning is raised.
- R4: In a control write, bit 4+i clears the timer pending bit of CPU i (`tmr_irq[i]`). Clearing a bit that is not pending has no effect and raises no warning.
- R5: Control-write bit 28 is a bus-error acknowledge. It is accepted without error and has no other effect. A control write in which bits 15:4 and bit 28 are all zero gets `rsp_err`=1 and changes no pending bit.
- R6: Posting an IPI that is already pending leaves it pending and pulses `warn_dup` with the response. Acknowledging an IPI that is not pending pulses `warn_spur` with the response.
- R7: Dedicated registers use data bits [NUM_CPU-1:0] as a CPU mask. A write to index 3 posts IPIs. A write to index 1 acknowledges IPIs. A write to index 2 clears timer bits. If the mask is all zero, the write gets `rsp_err`=1 and changes no state.
- R8: A cycle with `tick`=1 sets every CPU's timer pending bit. If a timer clear arrives in the same cycle, the tick wins.
- R9: Reads return values as follows. Index 1 returns IPI pending in bits [3:0]. Index 2 returns timer pending in bits [3:0]. Index 3 returns 0. Index 0 returns `req_cpu` in bits 1:0, timer pending in 7:4 and IPI pending in 11:8. Any index above 3 gets `rsp_err`=1 with read data 0.
- R10: `rsp_valid` is 1 exactly in the cycle after a cycle with `req_valid`=1. Read data, error and warnings are valid in that cycle and reflect the state before the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Periodic timer tick, one cycle per event |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 4 | Register index |
| req_wdata | input | 64 | Write data |
| req_cpu | input | 2 | Identity of the requesting CPU |
| rsp_valid | output | 1 | Response valid |
| rsp_rdata | output | 64 | Read data |
| rsp_err | output | 1 | Request rejected |
| warn_dup | output | 1 | Duplicate IPI post in the answered request |
| warn_spur | output | 1 | Acknowledge of a non-pending IPI in the answered request |
| ipi_irq | output | 4 | Per-CPU IPI interrupt lines |
| tmr_irq | output | 4 | Per-CPU timer interrupt lines |

## Verification
Several properties are checked on every cycle:
- every decoded IPI post shows up on `ipi_irq` in the next cycle;
- a pure acknowledge drops its lines;
- a tick fills `tmr_irq`;
- a rejected request leaves the IPI lines unchanged;
- the response follows the request by exactly one cycle, and warnings only accompany accepted responses.

The directed scenarios cover what the properties cannot see: reset values, the nibble field positions, clear-before-post ordering in one write, tick-versus-clear priority, the packed control readback with the CPU identity, and the rejection of empty masks and unmapped indices.

// File: rtl/cpu_irq_pkg.sv
package cpu_irq_pkg;
  localparam int REG_W  = 64;
  localparam int REG_AW = 4;
  localparam int CID_W  = 2;
  localparam int NIB_W  = 4;

  localparam int FLD_POST_LSB    = 12;
  localparam int FLD_ACK_LSB     = 8;
  localparam int FLD_TCLR_LSB    = 4;
  localparam int FLD_BERR_BIT    = 28;
  localparam int RD_TMR_LSB      = 4;
  localparam int RD_IPI_LSB      = 8;

  typedef enum logic [REG_AW-1:0] {
    RA_CTRL     = 4'd0,
    RA_IPI_PEND = 4'd1,
    RA_TMR_PEND = 4'd2,
    RA_IPI_POST = 4'd3
  } reg_addr_e;

  function automatic logic [NIB_W-1:0] nibble_at(input logic [REG_W-1:0] w, input int unsigned lsb);
    return w[lsb +: NIB_W];
  endfunction

  function automatic logic [REG_W-1:0] pack_ctrl(input logic [CID_W-1:0] cid,
                                                 input logic [NIB_W-1:0] tmr,
                                                 input logic [NIB_W-1:0] ipi);
    logic [REG_W-1:0] r;
    r = '0;
    r[CID_W-1:0] = cid;
    r[RD_TMR_LSB +: NIB_W] = tmr;
    r[RD_IPI_LSB +: NIB_W] = ipi;
    return r;
  endfunction

  function automatic logic [NIB_W-1:0] next_pend(input logic [NIB_W-1:0] cur,
                                                 input logic [NIB_W-1:0] clr,
                                                 input logic [NIB_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
  import cpu_irq_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [REG_AW-1:0]  req_addr,
  input  logic [REG_W-1:0]   req_wdata,
  input  logic [NUM_CPU-1:0] ipi_pend,
  output logic [NUM_CPU-1:0] ipi_set,
  output logic [NUM_CPU-1:0] ipi_clr,
  output logic [NUM_CPU-1:0] tmr_clr,
  output logic               cmd_err,
  output logic [NUM_CPU-1:0] dup_mask,
  output logic [NUM_CPU-1:0] spur_mask
);
  logic [NIB_W-1:0]   post_nib, ack_nib, tclr_nib;
  logic [NUM_CPU-1:0] post_f, ack_f, tclr_f, mask_f;
  logic               berr_f, any_f;
  logic               unused_bits;

  assign unused_bits = ^req_wdata;

  always_comb begin
    post_nib = nibble_at(req_wdata, FLD_POST_LSB);
    ack_nib  = nibble_at(req_wdata, FLD_ACK_LSB);
    tclr_nib = nibble_at(req_wdata, FLD_TCLR_LSB);
    post_f   = post_nib[NUM_CPU-1:0];
    ack_f    = ack_nib[NUM_CPU-1:0];
    tclr_f   = tclr_nib[NUM_CPU-1:0];
    berr_f   = req_wdata[FLD_BERR_BIT];
    mask_f   = req_wdata[NUM_CPU-1:0];
    any_f    = (|post_f) | (|ack_f) | (|tclr_f) | berr_f;
  end

  always_comb begin
    ipi_set = '0;
    ipi_clr = '0;
    tmr_clr = '0;
    cmd_err = 1'b0;
    if (req_valid) begin
      if (req_write) begin
        case (req_addr)
          RA_CTRL: begin
            if (any_f) begin
              ipi_set = post_f;
              ipi_clr = ack_f;
              tmr_clr = tclr_f;
            end else begin
              cmd_err = 1'b1;
            end
          end
          RA_IPI_PEND: begin
            if (|mask_f) ipi_clr = mask_f;
            else         cmd_err = 1'b1;
          end
          RA_TMR_PEND: begin
            if (|mask_f) tmr_clr = mask_f;
            else         cmd_err = 1'b1;
          end
          RA_IPI_POST: begin
            if (|mask_f) ipi_set = mask_f;
            else         cmd_err = 1'b1;
          end
          default: cmd_err = 1'b1;
        endcase
      end else begin
        cmd_err = (req_addr > RA_IPI_POST);
      end
    end
  end

  // clear-before-post: a post only duplicates what survives the clear
  assign dup_mask  = ipi_set & ipi_pend & ~ipi_clr;
  assign spur_mask = ipi_clr & ~ipi_pend;
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
  import cpu_irq_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CPU-1:0] set_mask,
  input  logic [NUM_CPU-1:0] clr_mask,
  output logic [NUM_CPU-1:0] pend
);
  logic [NIB_W-1:0] cur4, set4, clr4, nxt4;

  always_comb begin
    cur4 = '0; set4 = '0; clr4 = '0;
    cur4[NUM_CPU-1:0] = pend;
    set4[NUM_CPU-1:0] = set_mask;
    clr4[NUM_CPU-1:0] = clr_mask;
    nxt4 = next_pend(cur4, clr4, set4);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= nxt4[NUM_CPU-1:0];
  end
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import cpu_irq_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input  logic [REG_AW-1:0]  rd_addr,
  input  logic [CID_W-1:0]   rd_cpu,
  input  logic [NUM_CPU-1:0] ipi_pend,
  input  logic [NUM_CPU-1:0] tmr_pend,
  output logic [REG_W-1:0]   rd_data
);
  logic [NIB_W-1:0] ipi4, tmr4;

  always_comb begin
    ipi4 = '0; tmr4 = '0;
    ipi4[NUM_CPU-1:0] = ipi_pend;
    tmr4[NUM_CPU-1:0] = tmr_pend;
    case (rd_addr)
      RA_CTRL:     rd_data = pack_ctrl(rd_cpu, tmr4, ipi4);
      RA_IPI_PEND: rd_data = REG_W'(ipi4);
      RA_TMR_PEND: rd_data = REG_W'(tmr4);
      default:     rd_data = '0;
    endcase
  end
endmodule

// File: rtl/cpu_irq_hub.sv
module cpu_irq_hub
  import cpu_irq_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [REG_AW-1:0]  req_addr,
  input  logic [REG_W-1:0]   req_wdata,
  input  logic [CID_W-1:0]   req_cpu,
  output logic               rsp_valid,
  output logic [REG_W-1:0]   rsp_rdata,
  output logic               rsp_err,
  output logic               warn_dup,
  output logic               warn_spur,
  output logic [NUM_CPU-1:0] ipi_irq,
  output logic [NUM_CPU-1:0] tmr_irq
);
  logic [NUM_CPU-1:0] ipi_pend, tmr_pend;
  logic [NUM_CPU-1:0] ipi_set_w, ipi_clr_w, tmr_clr_w, tmr_set_w;
  logic [NUM_CPU-1:0] dup_w, spur_w;
  logic               dec_err_w;
  logic [REG_W-1:0]   rd_w;

  irq_cmd_decode #(.NUM_CPU(NUM_CPU)) dec_i (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .ipi_pend  (ipi_pend),
    .ipi_set   (ipi_set_w),
    .ipi_clr   (ipi_clr_w),
    .tmr_clr   (tmr_clr_w),
    .cmd_err   (dec_err_w),
    .dup_mask  (dup_w),
    .spur_mask (spur_w)
  );

  assign tmr_set_w = {NUM_CPU{tick}};

  irq_pend_bank #(.NUM_CPU(NUM_CPU)) ipi_bank_i (
    .clk (clk), .rst_n (rst_n),
    .set_mask (ipi_set_w), .clr_mask (ipi_clr_w), .pend (ipi_pend)
  );

  irq_pend_bank #(.NUM_CPU(NUM_CPU)) tmr_bank_i (
    .clk (clk), .rst_n (rst_n),
    .set_mask (tmr_set_w), .clr_mask (tmr_clr_w), .pend (tmr_pend)
  );

  irq_read_mux #(.NUM_CPU(NUM_CPU)) rd_i (
    .rd_addr  (req_addr),
    .rd_cpu   (req_cpu),
    .ipi_pend (ipi_pend),
    .tmr_pend (tmr_pend),
    .rd_data  (rd_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
      warn_dup  <= 1'b0;
      warn_spur <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= dec_err_w;
      rsp_rdata <= (req_valid && !req_write && !dec_err_w) ? rd_w : '0;
      warn_dup  <= |dup_w;
      warn_spur <= |spur_w;
    end
  end

  assign ipi_irq = ipi_pend;
  assign tmr_irq = tmr_pend;
endmodule

// File: rtl/cpu_irq_hub_chk.sv
module cpu_irq_hub_chk #(
  parameter int NUM_CPU = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic               req_valid,
  input logic               rsp_valid,
  input logic               rsp_err,
  input logic               warn_dup,
  input logic               warn_spur,
  input logic [NUM_CPU-1:0] ipi_irq,
  input logic [NUM_CPU-1:0] tmr_irq,
  input logic [NUM_CPU-1:0] ipi_set_w,
  input logic [NUM_CPU-1:0] ipi_clr_w,
  input logic               dec_err_w
);
  AST_POST_LANDS: assert property (@(posedge clk) disable iff (!rst_n) (ipi_set_w != '0) |=> ((ipi_irq & $past(ipi_set_w)) == $past(ipi_set_w))); // R2
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n) (ipi_clr_w != '0 && ipi_set_w == '0) |=> ((ipi_irq & $past(ipi_clr_w)) == '0)); // R3
  AST_ERR_KEEPS_IPI: assert property (@(posedge clk) disable iff (!rst_n) dec_err_w |=> $stable(ipi_irq)); // R5
  AST_WARN_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) (warn_dup || warn_spur) |-> (rsp_valid && !rsp_err)); // R6
  AST_TICK_FILLS: assert property (@(posedge clk) disable iff (!rst_n) tick |=> (tmr_irq == {NUM_CPU{1'b1}})); // R8
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> rsp_valid); // R10
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !rsp_valid); // R10
endmodule

bind cpu_irq_hub cpu_irq_hub_chk #(.NUM_CPU(NUM_CPU)) chk_i (
  .clk (clk), .rst_n (rst_n), .tick (tick), .req_valid (req_valid),
  .rsp_valid (rsp_valid), .rsp_err (rsp_err), .warn_dup (warn_dup),
  .warn_spur (warn_spur), .ipi_irq (ipi_irq), .tmr_irq (tmr_irq),
  .ipi_set_w (ipi_set_w), .ipi_clr_w (ipi_clr_w), .dec_err_w (dec_err_w)
);

// File: tb/cpu_irq_hub_tb_top.sv
`timescale 1ns/1ps
module cpu_irq_hub_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [1:0]  req_cpu = '0;
  logic        rsp_valid, rsp_err, warn_dup, warn_spur;
  logic [63:0] rsp_rdata;
  logic [3:0]  ipi_irq, tmr_irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cpu_irq_hub dut_i (
    .clk (clk), .rst_n (rst_n), .tick (tick), .req_valid (req_valid),
    .req_write (req_write), .req_addr (req_addr), .req_wdata (req_wdata),
    .req_cpu (req_cpu), .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
    .rsp_err (rsp_err), .warn_dup (warn_dup), .warn_spur (warn_spur),
    .ipi_irq (ipi_irq), .tmr_irq (tmr_irq)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    check(act === exp, tag, act, exp);
  endtask

  logic        r_err, r_dup, r_spur;
  logic [63:0] r_data;

  task automatic bus_op(input logic wr, input logic [3:0] a, input logic [63:0] d,
                        input logic [1:0] cid, input logic tk);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_cpu = cid; tick = tk;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; tick = 1'b0;
    r_err = rsp_err; r_data = rsp_rdata; r_dup = warn_dup; r_spur = warn_spur;
    eq("R10 rsp_valid after request", {63'b0, rsp_valid}, 64'd1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    eq("R1 ipi_irq after reset", {60'b0, ipi_irq}, 64'h0);
    eq("R1 tmr_irq after reset", {60'b0, tmr_irq}, 64'h0);
    eq("R1 warnings after reset", {62'b0, warn_dup, warn_spur}, 64'h0);
    eq("R1 rsp_valid after reset", {63'b0, rsp_valid}, 64'h0);
  endtask

  task automatic t_post;
    bus_op(1'b1, 4'd0, 64'h5000, 2'd0, 1'b0);
    eq("R2 post err", {63'b0, r_err}, 64'h0);
    eq("R2 post cpus 0,2", {60'b0, ipi_irq}, 64'h5);
    eq("R2 no warning", {62'b0, r_dup, r_spur}, 64'h0);
    bus_op(1'b0, 4'd1, 64'h0, 2'd0, 1'b0);
    eq("R9 ipi pending readback", r_data, 64'h5);
  endtask

  task automatic t_clear;
    bus_op(1'b1, 4'd0, 64'h0100, 2'd0, 1'b0);
    eq("R3 ack cpu0", {60'b0, ipi_irq}, 64'h4);
    bus_op(1'b1, 4'd0, 64'h4400, 2'd0, 1'b0);
    eq("R3 ack then post same cpu", {60'b0, ipi_irq}, 64'h4);
    eq("R3 no warning for ack+post", {62'b0, r_dup, r_spur}, 64'h0);
  endtask

  task automatic t_warn;
    bus_op(1'b1, 4'd0, 64'h4000, 2'd0, 1'b0);
    eq("R6 dup warn", {63'b0, r_dup}, 64'h1);
    eq("R6 dup leaves pending", {60'b0, ipi_irq}, 64'h4);
    bus_op(1'b1, 4'd0, 64'h0200, 2'd0, 1'b0);
    eq("R6 spurious warn", {63'b0, r_spur}, 64'h1);
    eq("R6 spurious leaves state", {60'b0, ipi_irq}, 64'h4);
    bus_op(1'b0, 4'd1, 64'h0, 2'd0, 1'b0);
    eq("R6 warnings are pulses", {62'b0, r_dup, r_spur}, 64'h0);
  endtask

  task automatic t_timer;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    eq("R8 tick sets all", {60'b0, tmr_irq}, 64'hF);
    bus_op(1'b1, 4'd0, 64'h0030, 2'd0, 1'b0);
    eq("R4 control clears timer 0,1", {60'b0, tmr_irq}, 64'hC);
    eq("R4 no warning on timer clear", {62'b0, r_dup, r_spur}, 64'h0);
    bus_op(1'b1, 4'd0, 64'h0030, 2'd0, 1'b0);
    eq("R4 clear of idle timer no warn", {62'b0, r_dup, r_spur}, 64'h0);
    bus_op(1'b1, 4'd2, 64'h4, 2'd0, 1'b1);
    eq("R8 tick beats clear", {60'b0, tmr_irq}, 64'hF);
    bus_op(1'b1, 4'd2, 64'h3, 2'd0, 1'b0);
    eq("R7 dedicated timer clear", {60'b0, tmr_irq}, 64'hC);
  endtask

  task automatic t_berr;
    bus_op(1'b1, 4'd0, 64'h1000_0000, 2'd0, 1'b0);
    eq("R5 bus-error ack accepted", {63'b0, r_err}, 64'h0);
    eq("R5 bus-error ack no ipi effect", {60'b0, ipi_irq}, 64'h4);
    eq("R5 bus-error ack no timer effect", {60'b0, tmr_irq}, 64'hC);
    bus_op(1'b1, 4'd0, 64'h0, 2'd0, 1'b0);
    eq("R5 empty control write err", {63'b0, r_err}, 64'h1);
    bus_op(1'b1, 4'd0, 64'hFFFF_0000_EFFF_000F, 2'd0, 1'b0);
    eq("R5 non-field bits only err", {63'b0, r_err}, 64'h1);
    eq("R5 rejected write keeps ipi", {60'b0, ipi_irq}, 64'h4);
    eq("R5 rejected write keeps timer", {60'b0, tmr_irq}, 64'hC);
  endtask

  task automatic t_dedicated;
    bus_op(1'b1, 4'd3, 64'h3, 2'd0, 1'b0);
    eq("R7 dedicated post", {60'b0, ipi_irq}, 64'h7);
    bus_op(1'b1, 4'd1, 64'h5, 2'd0, 1'b0);
    eq("R7 dedicated ipi ack", {60'b0, ipi_irq}, 64'h2);
    bus_op(1'b1, 4'd2, 64'h0, 2'd0, 1'b0);
    eq("R7 empty timer mask err", {63'b0, r_err}, 64'h1);
    eq("R7 empty timer mask keeps", {60'b0, tmr_irq}, 64'hC);
    bus_op(1'b1, 4'd3, 64'hF0, 2'd0, 1'b0);
    eq("R7 empty post mask err", {63'b0, r_err}, 64'h1);
    eq("R7 empty post mask keeps", {60'b0, ipi_irq}, 64'h2);
    bus_op(1'b1, 4'd1, 64'h0, 2'd0, 1'b0);
    eq("R7 empty ack mask err", {63'b0, r_err}, 64'h1);
  endtask

  task automatic t_reads;
    bus_op(1'b0, 4'd0, 64'h0, 2'd2, 1'b0);
    eq("R9 control read packing", r_data, 64'h2C2);
    eq("R9 control read no err", {63'b0, r_err}, 64'h0);
    bus_op(1'b0, 4'd0, 64'h0, 2'd3, 1'b0);
    eq("R9 control read cpu id 3", r_data, 64'h2C3);
    bus_op(1'b0, 4'd2, 64'h0, 2'd0, 1'b0);
    eq("R9 timer readback", r_data, 64'hC);
    bus_op(1'b0, 4'd3, 64'h0, 2'd0, 1'b0);
    eq("R9 post register reads zero", r_data, 64'h0);
    bus_op(1'b0, 4'd9, 64'h0, 2'd0, 1'b0);
    eq("R9 unmapped read err", {63'b0, r_err}, 64'h1);
    eq("R9 unmapped read data", r_data, 64'h0);
    bus_op(1'b1, 4'd9, 64'hF, 2'd0, 1'b0);
    eq("R9 unmapped write err", {63'b0, r_err}, 64'h1);
  endtask

  task automatic t_idle;
    @(negedge clk);
    @(negedge clk);
    eq("R10 no response when idle", {63'b0, rsp_valid}, 64'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_post();
    t_clear();
    t_warn();
    t_timer();
    t_berr();
    t_dedicated();
    t_reads();
    t_idle();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule